// File: doc/BRIEF.md
# Autoprecharge Command Spacing Checker

This block watches the command stream that a memory controller sends to a multi-bank DRAM. It enforces the minimum spacing between a read or write that carries an automatic precharge and the next command that targets a different bank. On every clock it takes one command code, the bank it addresses, and the programmed read latency, write latency and write-to-read turnaround, all counted in clocks. The gap that applies depends on the direction of the turnaround. A write followed by a read must wait for the write latency plus two clocks plus the turnaround time. A read followed by a write must wait for the read latency plus four clocks minus the write latency. Every other transition needs only one or two clocks.

The block keeps one countdown for each destination class: reads, writes, and row commands (precharge and activate). Each countdown is reloaded whenever a new autoprecharge command is issued. The block drives one "allowed" output per class, which a scheduler can use to gate its choice. When used as a monitor, it raises a sticky violation flag and records the first command that broke a window. A command to the bank that opened the current window is outside the scope of this check and passes without being flagged.

Top module: `apc_spacing_checker`

## Requirements
- R1: Command codes are NOP=0, RD=1, RD/A=2, WR=3, WR/A=4, PRE=5, ACT=6. Code 7 behaves as NOP. RD and RD/A form the read class, WR and WR/A the write class, PRE and ACT the row class.
- R2: After a WR/A in cycle t, a read to another bank is allowed from cycle t+WL+2+tWTR on.
- R3: After a WR/A in cycle t, a write to another bank is allowed from cycle t+2 on.
- R4: After an RD/A in cycle t, a read to another bank is allowed from cycle t+2 on.
- R5: After an RD/A in cycle t, a write to another bank is allowed from cycle t+CL+4−WL on. When that value is below t+1, the gap is clamped to one clock.
- R6: Row commands (PRE, ACT) are always allowed one clock after any autoprecharge command, so `allowRow` never drops.
- R7: A command to the bank that opened the current window of its class is never flagged.
- R8: When a new autoprecharge command arrives while a window is open, each class keeps the later of its current end and the new end. If the new end is later or equal, the window's bank becomes the new command's bank.
- R9: A command of class k, issued while `allowX` of k is low and aimed at another bank, sets `violation` one clock later. `violation` then stays high until reset. `violCmd` and `violBank` hold the code and bank of the first such command.
- R10: After reset all three allow outputs are high and `violation` is low.
- R11: Each allow output is high in exactly those cycles in which a command of its class to another bank would not be flagged, under any mix of commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdCode | input | 3 | Command issued this cycle (R1 encoding) |
| cmdBank | input | BANK_W | Bank addressed by the command |
| cfgCl | input | CNT_W | Read latency in clocks |
| cfgWl | input | CNT_W | Write latency in clocks |
| cfgTwtr | input | CNT_W | Write-to-read turnaround in clocks |
| allowRead | output | 1 | A read to another bank may issue this cycle |
| allowWrite | output | 1 | A write to another bank may issue this cycle |
| allowRow | output | 1 | A PRE or ACT to another bank may issue this cycle |
| violation | output | 1 | Sticky flag for a spacing violation |
| violCmd | output | 3 | Code of the first offending command |
| violBank | output | BANK_W | Bank of the first offending command |

## Verification
Several properties are checked on every cycle. The violation flag and the recorded offender stay fixed once set. The row class is never blocked. A write-with-autoprecharge with a read gap above one clock closes the read window on the following clock. The decoded class is at most one-hot, and the read-to-write gap is never zero. Only the bench's scenarios can show the exact length of each window under a given latency setting, and the clamp of a negative read-to-write gap. They also show the same-bank exemption, the rule that the longer of two overlapping windows wins, and the agreement between the allow outputs and the flagging over a long random command stream.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_RD  = 3'd1,
    CMD_RDA = 3'd2,
    CMD_WR  = 3'd3,
    CMD_WRA = 3'd4,
    CMD_PRE = 3'd5,
    CMD_ACT = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;

  localparam int NUM_CLS   = 3;
  localparam int CLS_READ  = 0;
  localparam int CLS_WRITE = 1;
  localparam int CLS_ROW   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic                load;    // autoprecharge command issued: reload windows
    logic [NUM_CLS-1:0]  hitCls;  // destination class of the current command
    cmd_e                cmd;     // decoded command, for the violation record
  } strobe_t;

endpackage

// File: rtl/apc_ctrl.sv
module apc_ctrl
  import apc_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int GAP_W = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [2:0]                       cmdCode,
  input  logic [CNT_W-1:0]                 cfgCl,
  input  logic [CNT_W-1:0]                 cfgWl,
  input  logic [CNT_W-1:0]                 cfgTwtr,
  output strobe_t                          stb,
  output logic [NUM_CLS-1:0][GAP_W-1:0]    gapLen
);

  cmd_e             cmd;
  logic             isRda;
  logic             isWra;
  logic [GAP_W-1:0] sumCl;
  logic [GAP_W-1:0] wlExt;
  logic [GAP_W-1:0] rdToWr;
  logic [GAP_W-1:0] wrToRd;

  assign cmd   = cmd_e'(cmdCode);
  assign isRda = (cmd == CMD_RDA);
  assign isWra = (cmd == CMD_WRA);

  always_comb begin
    sumCl  = GAP_W'(cfgCl) + GAP_W'(4);
    wlExt  = GAP_W'(cfgWl);
    rdToWr = (sumCl > wlExt + GAP_W'(1)) ? (sumCl - wlExt) : GAP_W'(1);
    wrToRd = GAP_W'(cfgWl) + GAP_W'(2) + GAP_W'(cfgTwtr);
  end

  always_comb begin
    gapLen[CLS_READ]  = isWra ? wrToRd    : GAP_W'(2);
    gapLen[CLS_WRITE] = isWra ? GAP_W'(2) : rdToWr;
    gapLen[CLS_ROW]   = GAP_W'(1);
  end

  always_comb begin
    stb.load   = isRda | isWra;
    stb.cmd    = cmd;
    stb.hitCls = '0;
    unique case (cmd)
      CMD_RD, CMD_RDA:  stb.hitCls[CLS_READ]  = 1'b1;
      CMD_WR, CMD_WRA:  stb.hitCls[CLS_WRITE] = 1'b1;
      CMD_PRE, CMD_ACT: stb.hitCls[CLS_ROW]   = 1'b1;
      default:          stb.hitCls = '0;
    endcase
  end

  // R1: a command belongs to at most one class
  a_r1_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb.hitCls));

  // R5: the read-to-write gap never collapses to zero
  a_r5_gap_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |-> (gapLen[CLS_WRITE] != '0));

endmodule

// File: rtl/apc_datapath.sv
module apc_datapath
  import apc_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int GAP_W  = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  strobe_t                        stb,
  input  logic [BANK_W-1:0]              cmdBank,
  input  logic [NUM_CLS-1:0][GAP_W-1:0]  gapLen,
  output logic [NUM_CLS-1:0]             allowVec,
  output logic                           violation,
  output logic [2:0]                     violCmd,
  output logic [BANK_W-1:0]              violBank
);

  logic [NUM_CLS-1:0] clash;

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
    logic [GAP_W-1:0]  cnt;
    logic [GAP_W-1:0]  curM1;
    logic [GAP_W-1:0]  newM1;
    logic [BANK_W-1:0] owner;
    logic              takeNew;

    assign curM1   = (cnt == '0) ? '0 : cnt - GAP_W'(1);
    assign newM1   = gapLen[i] - GAP_W'(1);
    assign takeNew = stb.load && (newM1 >= curM1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt   <= '0;
        owner <= '0;
      end else begin
        cnt <= takeNew ? newM1 : curM1;
        if (takeNew) owner <= cmdBank;
      end
    end

    assign allowVec[i] = (cnt == '0);
    assign clash[i]    = stb.hitCls[i] && !allowVec[i] && (cmdBank != owner);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violation <= 1'b0;
      violCmd   <= '0;
      violBank  <= '0;
    end else if (!violation && (|clash)) begin
      violation <= 1'b1;
      violCmd   <= stb.cmd;
      violBank  <= cmdBank;
    end
  end

  // R9: violation is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R9: the first offender record does not change
  a_r9_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> ($stable(violCmd) && $stable(violBank)));

  // R6: row commands are never blocked
  a_r6_row_open: assert property (@(posedge clk) disable iff (!rst_n)
    allowVec[CLS_ROW]);

  // R2: a long write-to-read gap closes the read window on the next clock
  a_r2_read_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.load && stb.hitCls[CLS_WRITE] && (gapLen[CLS_READ] > GAP_W'(1)))
      |=> !allowVec[CLS_READ]);

endmodule

// File: rtl/apc_spacing_checker.sv
module apc_spacing_checker
  import apc_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [CNT_W-1:0]  cfgCl,
  input  logic [CNT_W-1:0]  cfgWl,
  input  logic [CNT_W-1:0]  cfgTwtr,
  output logic              allowRead,
  output logic              allowWrite,
  output logic              allowRow,
  output logic              violation,
  output logic [2:0]        violCmd,
  output logic [BANK_W-1:0] violBank
);

  localparam int GAP_W = CNT_W + 2;

  strobe_t                        stb;
  logic [NUM_CLS-1:0][GAP_W-1:0]  gapLen;
  logic [NUM_CLS-1:0]             allowVec;

  apc_ctrl #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmdCode (cmdCode),
    .cfgCl   (cfgCl),
    .cfgWl   (cfgWl),
    .cfgTwtr (cfgTwtr),
    .stb     (stb),
    .gapLen  (gapLen)
  );

  apc_datapath #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .cmdBank   (cmdBank),
    .gapLen    (gapLen),
    .allowVec  (allowVec),
    .violation (violation),
    .violCmd   (violCmd),
    .violBank  (violBank)
  );

  assign allowRead  = allowVec[CLS_READ];
  assign allowWrite = allowVec[CLS_WRITE];
  assign allowRow   = allowVec[CLS_ROW];

endmodule

// File: tb/sim_apc_spacing_checker.sv
`timescale 1ns/1ps
module sim_apc_spacing_checker;
  localparam int BANK_W = 3;
  localparam int CNT_W  = 5;

  localparam int C_NOP = 0, C_RD = 1, C_RDA = 2, C_WR = 3, C_WRA = 4, C_PRE = 5, C_ACT = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cmdCode = '0;
  logic [BANK_W-1:0] cmdBank = '0;
  logic [CNT_W-1:0]  cfgCl = '0, cfgWl = '0, cfgTwtr = '0;
  logic              allowRead, allowWrite, allowRow, violation;
  logic [2:0]        violCmd;
  logic [BANK_W-1:0] violBank;

  always #4 clk = ~clk;

  apc_spacing_checker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cfgCl(cfgCl), .cfgWl(cfgWl), .cfgTwtr(cfgTwtr),
    .allowRead(allowRead), .allowWrite(allowWrite), .allowRow(allowRow),
    .violation(violation), .violCmd(violCmd), .violBank(violBank)
  );

  int    nRun = 0, nFail = 0;
  string curReq = "R10";
  int    cyc;
  int    readyAt[3];
  int    owner[3];
  bit    mViol;
  int    mCmd, mBank;

  task automatic chk(string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  function automatic int clsOf(int c);
    if (c == C_RD || c == C_RDA) return 0;
    if (c == C_WR || c == C_WRA) return 1;
    if (c == C_PRE || c == C_ACT) return 2;
    return -1;
  endfunction

  task automatic mreset();
    rst_n = 1'b0;
    cmdCode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    mViol = 0;
    for (int i = 0; i < 3; i++) begin readyAt[i] = 0; owner[i] = 0; end
  endtask

  // at a negedge: compare outputs with the model, drive one command, advance
  task automatic step(int c, int b);
    int k;
    int g[3];
    chk("allowRead",  int'(allowRead),  int'(cyc >= readyAt[0]));
    chk("allowWrite", int'(allowWrite), int'(cyc >= readyAt[1]));
    chk("allowRow",   int'(allowRow),   int'(cyc >= readyAt[2]));
    chk("violation",  int'(violation),  int'(mViol));
    if (mViol) begin
      chk("violCmd",  int'(violCmd),  mCmd);
      chk("violBank", int'(violBank), mBank);
    end
    cmdCode = 3'(c);
    cmdBank = BANK_W'(b);
    k = clsOf(c);
    if (k >= 0 && !mViol && cyc < readyAt[k] && b != owner[k]) begin
      mViol = 1; mCmd = c; mBank = b;
    end
    if (c == C_WRA || c == C_RDA) begin
      if (c == C_WRA) begin
        g[0] = int'(cfgWl) + 2 + int'(cfgTwtr);
        g[1] = 2;
      end else begin
        g[0] = 2;
        g[1] = int'(cfgCl) + 4 - int'(cfgWl);
        if (g[1] < 1) g[1] = 1;
      end
      g[2] = 1;
      for (int i = 0; i < 3; i++)
        if (cyc + g[i] >= readyAt[i]) begin readyAt[i] = cyc + g[i]; owner[i] = b; end
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(C_NOP, 0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    cfgCl = 5; cfgWl = 3; cfgTwtr = 2;

    // R10: reset state
    curReq = "R10"; mreset();
    idle(2);

    // R2: write-autoprecharge to read window of WL+2+tWTR
    curReq = "R2"; mreset();
    step(C_WRA, 0); idle(6); step(C_RD, 1); idle(3);

    // R3: write-autoprecharge to write at two clocks
    curReq = "R3"; mreset();
    step(C_WRA, 1); step(C_NOP, 0); step(C_WR, 2); idle(8);

    // R4: read-autoprecharge to read at two clocks
    curReq = "R4"; mreset();
    step(C_RDA, 0); step(C_NOP, 0); step(C_RD, 1); idle(8);

    // R5: read-autoprecharge to write at CL+4-WL
    curReq = "R5"; mreset();
    step(C_RDA, 0); idle(5); step(C_WR, 2); idle(3);
    // R5: clamp when WL exceeds CL+4
    curReq = "R5"; cfgCl = 2; cfgWl = 9; mreset();
    step(C_RDA, 0); step(C_WR, 3); idle(3);
    cfgCl = 5; cfgWl = 3;

    // R6: row commands one clock later
    curReq = "R6"; mreset();
    step(C_WRA, 0); step(C_PRE, 1); step(C_ACT, 2); step(C_RDA, 3); step(C_ACT, 4); idle(8);

    // R7: same bank passes unchecked
    curReq = "R7"; mreset();
    step(C_WRA, 3); step(C_RD, 3); step(C_WR, 3); idle(8);

    // R8: overlapping windows keep the later end
    curReq = "R8"; cfgTwtr = 6; mreset();
    step(C_WRA, 0); cfgTwtr = 0;
    step(C_NOP, 0); step(C_WRA, 1); idle(5); step(C_RD, 1); idle(4);
    cfgTwtr = 2;

    // R9: sticky flag and first offender
    curReq = "R9"; mreset();
    step(C_WRA, 0); step(C_RD, 1); step(C_RD, 2); step(C_WR, 5); idle(4);

    // R1: reserved code behaves as NOP
    curReq = "R1"; mreset();
    step(7, 1); step(C_WRA, 0); step(7, 2); step(C_RD, 2); idle(3);

    // R11: random command mix
    curReq = "R11";
    for (int r = 0; r < 20; r++) begin
      cfgCl = CNT_W'($urandom_range(1, 12));
      cfgWl = CNT_W'($urandom_range(1, 10));
      cfgTwtr = CNT_W'($urandom_range(0, 6));
      mreset();
      for (int i = 0; i < 60; i++) begin
        int c;
        c = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : C_NOP;
        step(c, int'($urandom_range(0, 7)));
      end
    end

    finishRun();
  end
endmodule